// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Logic

This block builds the eight-bit status byte of a bus-attached instrument from four live condition flags: the output queue holding responses, the fault queue holding entries, a power-supply fault, and the event summary coming from the event status logic. It keeps a service request enable register that a host command layer writes and reads. The enable register selects which status conditions raise the master summary bit.

The block has two read views of the status byte. The status query view carries the master summary bit in bit 6. The serial poll view carries a request-service bit in that position instead. The request-service bit is set when the summary bit rises and stays set until a poll clears it. The poll does not change the summary bit. All outputs come from registers on one clock, with a synchronous active-high reset.

Top module: `stb_srq_core`

## Requirements
- R1: `status_byte` places the summary bit at bit 6, the event summary at bit 5, message-available at bit 4, the fault flag at bit 3 and the power-supply fault at bit 2. Each condition bit follows its input one clock edge after it is sampled.
- R2: Bits 7, 1 and 0 of `status_byte` and `poll_byte` always read as zero.
- R3: Message-available (bit 4) is 1 while `outq_busy` is high and 0 while it is low, one edge later.
- R4: The summary bit (bit 6) is 1 after an edge when any of enable bits 5, 4 or 3 was set together with the matching condition input at that edge. Otherwise it is 0.
- R5: The enable register stores only bits 5, 4 and 3. Writing 255 reads back 56, and enable bits 7, 6, 2, 1 and 0 never affect the summary bit.
- R6: Reset clears the enable register, both status views and `srq` to zero.
- R7: `poll_byte` equals `status_byte` except in bit 6, which carries the request-service bit. `srq` mirrors that bit.
- R8: The request-service bit is set at the same edge on which the summary bit goes from 0 to 1. It stays set while the summary bit holds, until a poll clears it.
- R9: A `poll_rd` pulse clears the request-service bit at that edge and leaves the summary bit unchanged. A summary rise at the same edge sets the bit, and the set takes priority over the clear.
- R10: A write with `ena_wr` high appears on `ena_rdata` one edge later. The new enable value governs the summary bit from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| outq_busy | input | 1 | Output queue holds at least one response |
| faultq_busy | input | 1 | Fault queue holds at least one entry |
| psu_fault | input | 1 | Power-supply fault present |
| event_sum | input | 1 | Event summary from the event status logic |
| ena_wr | input | 1 | Enable register write strobe |
| ena_wdata | input | 8 | Enable register write value |
| poll_rd | input | 1 | Serial poll read strobe; clears the request-service bit |
| ena_rdata | output | 8 | Enable register read value |
| status_byte | output | 8 | Status query view, summary bit in bit 6 |
| poll_byte | output | 8 | Serial poll view, request-service bit in bit 6 |
| srq | output | 1 | Service request flag |

## Verification
The hardest situation to reach is a poll that lands on the same edge as a new summary rise. This is the only case in which the set/clear priority of the request-service bit shows. To reach it, the stimulus first lets the summary bit fall. In the cycle that re-raises it, the stimulus asserts `poll_rd` together with the returning condition, so one step both rises the summary bit and polls. A related step polls while the summary bit stays high. The bench then confirms that the request-service bit drops and is not set again, and that the summary bit stays at 1.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int STB_W   = 8;
    localparam int POS_MSS = 6;
    localparam int POS_ESB = 5;
    localparam int POS_MAV = 4;
    localparam int POS_FLT = 3;
    localparam int POS_PSF = 2;

    // Enable bits that can be stored: event summary, message-available, fault
    localparam logic [STB_W-1:0] ENA_KEEP =
        (STB_W'(1) << POS_ESB) | (STB_W'(1) << POS_MAV) | (STB_W'(1) << POS_FLT);

    typedef struct packed {
        logic esb;
        logic mav;
        logic flt;
        logic psf;
    } cond_t;

    // Place the condition flags at their bit weights; bit 6 is given separately
    function automatic logic [STB_W-1:0] pack_byte(input logic top6, input cond_t c);
        logic [STB_W-1:0] b;
        b          = '0;
        b[POS_MSS] = top6;
        b[POS_ESB] = c.esb;
        b[POS_MAV] = c.mav;
        b[POS_FLT] = c.flt;
        b[POS_PSF] = c.psf;
        return b;
    endfunction

endpackage

// File: rtl/stb_enable_reg.sv
module stb_enable_reg
    import stb_pkg::*;
#(
    parameter logic [STB_W-1:0] KEEP = ENA_KEEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [STB_W-1:0] wdata,
    output logic [STB_W-1:0] ena_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= '0;
        end else if (wr) begin
            ena_q <= wdata & KEEP;
        end
    end

    // R5 R10
    ena_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> ena_q == ($past(wdata) & KEEP));

    // R5
    ena_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ena_q));

endmodule

// File: rtl/stb_cond_capture.sv
module stb_cond_capture
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cond_t            cond_in,
    input  logic [STB_W-1:0] ena,
    output cond_t            cond_q,
    output logic             mss_d,
    output logic             mss_q
);

    logic [STB_W-1:0] live_byte;

    always_comb begin
        live_byte = pack_byte(1'b0, cond_in);
        mss_d     = |(live_byte & ena & ENA_KEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            mss_q  <= 1'b0;
        end else begin
            cond_q <= cond_in;
            mss_q  <= mss_d;
        end
    end

    // R3
    mav_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cond_in.mav |=> cond_q.mav);

    // R4
    mss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(cond_in.esb && ena[POS_ESB]) && !(cond_in.mav && ena[POS_MAV])
        && !(cond_in.flt && ena[POS_FLT]) |=> !mss_q);

    // R4
    mss_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_in.flt && ena[POS_FLT]) |=> mss_q);

endmodule

// File: rtl/stb_srq_latch.sv
module stb_srq_latch (
    input  logic clk,
    input  logic rst,
    input  logic mss_d,
    input  logic mss_q,
    input  logic poll_rd,
    output logic rqs_q
);

    logic rise;

    always_comb rise = mss_d & ~mss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rqs_q <= 1'b0;
        end else if (rise) begin
            rqs_q <= 1'b1;
        end else if (poll_rd) begin
            rqs_q <= 1'b0;
        end
    end

    // R8
    rqs_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mss_q) |-> rqs_q);

    // R8
    rqs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rqs_q && !poll_rd |=> rqs_q);

    // R9
    rqs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        poll_rd && !(mss_d && !mss_q) |=> !rqs_q);

    // R9
    poll_no_mss_chk: assert property (@(posedge clk) disable iff (rst)
        poll_rd && mss_q && mss_d |=> mss_q);

endmodule

// File: rtl/stb_srq_core.sv
module stb_srq_core
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             outq_busy,
    input  logic             faultq_busy,
    input  logic             psu_fault,
    input  logic             event_sum,
    input  logic             ena_wr,
    input  logic [STB_W-1:0] ena_wdata,
    input  logic             poll_rd,
    output logic [STB_W-1:0] ena_rdata,
    output logic [STB_W-1:0] status_byte,
    output logic [STB_W-1:0] poll_byte,
    output logic             srq
);

    cond_t            cond_in;
    cond_t            cond_q;
    logic [STB_W-1:0] ena_q;
    logic             mss_d;
    logic             mss_q;
    logic             rqs_q;

    always_comb begin
        cond_in.esb = event_sum;
        cond_in.mav = outq_busy;
        cond_in.flt = faultq_busy;
        cond_in.psf = psu_fault;
    end

    stb_enable_reg #(.KEEP(ENA_KEEP)) u_ena (
        .clk   (clk),
        .rst   (rst),
        .wr    (ena_wr),
        .wdata (ena_wdata),
        .ena_q (ena_q)
    );

    stb_cond_capture u_cond (
        .clk     (clk),
        .rst     (rst),
        .cond_in (cond_in),
        .ena     (ena_q),
        .cond_q  (cond_q),
        .mss_d   (mss_d),
        .mss_q   (mss_q)
    );

    stb_srq_latch u_srq (
        .clk     (clk),
        .rst     (rst),
        .mss_d   (mss_d),
        .mss_q   (mss_q),
        .poll_rd (poll_rd),
        .rqs_q   (rqs_q)
    );

    always_comb begin
        status_byte = pack_byte(mss_q, cond_q);
        poll_byte   = pack_byte(rqs_q, cond_q);
        ena_rdata   = ena_q;
        srq         = rqs_q;
    end

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_byte[7] == 1'b0 && status_byte[1:0] == 2'b00
        && poll_byte[7] == 1'b0 && poll_byte[1:0] == 2'b00);

    // R7
    views_match_chk: assert property (@(posedge clk) disable iff (rst)
        (status_byte ^ poll_byte) == ({7'd0, mss_q ^ srq} << POS_MSS));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) && rst |-> status_byte == 8'd0 && poll_byte == 8'd0
        && ena_rdata == 8'd0 && !srq);

endmodule

// File: tb/sim_stb_srq_core.sv
module sim_stb_srq_core;

    logic       clk = 1'b0;
    logic       rst;
    logic       outq_busy, faultq_busy, psu_fault, event_sum;
    logic       ena_wr, poll_rd;
    logic [7:0] ena_wdata;
    logic [7:0] ena_rdata, status_byte, poll_byte;
    logic       srq;

    always #4 clk = ~clk;   // 125 MHz

    stb_srq_core u0 (
        .clk         (clk),
        .rst         (rst),
        .outq_busy   (outq_busy),
        .faultq_busy (faultq_busy),
        .psu_fault   (psu_fault),
        .event_sum   (event_sum),
        .ena_wr      (ena_wr),
        .ena_wdata   (ena_wdata),
        .poll_rd     (poll_rd),
        .ena_rdata   (ena_rdata),
        .status_byte (status_byte),
        .poll_byte   (poll_byte),
        .srq         (srq)
    );

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic [7:0] pl;
        logic [7:0] en;
        logic       sr;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   done   = 0;

    // reference state, from the requirements
    logic [7:0] m_en  = 8'd0;
    logic       m_mss = 1'b0;
    logic       m_rqs = 1'b0;

    task automatic step(input string tag, input logic r, input logic oq, input logic fq,
                        input logic pf, input logic es, input logic wr,
                        input logic [7:0] wd, input logic pr);
        exp_t e;
        logic mss_n, rqs_n;
        @(negedge clk);
        rst = r; outq_busy = oq; faultq_busy = fq; psu_fault = pf;
        event_sum = es; ena_wr = wr; ena_wdata = wd; poll_rd = pr;
        if (r) begin
            m_en = 8'd0; m_mss = 1'b0; m_rqs = 1'b0;
            oq = 1'b0; fq = 1'b0; pf = 1'b0; es = 1'b0;
        end else begin
            mss_n = (es & m_en[5]) | (oq & m_en[4]) | (fq & m_en[3]);
            rqs_n = (mss_n && !m_mss) ? 1'b1 : (pr ? 1'b0 : m_rqs);
            if (wr) m_en = wd & 8'h38;
            m_mss = mss_n;
            m_rqs = rqs_n;
        end
        e.tag = tag;
        e.st  = {1'b0, m_mss, es, oq, fq, pf, 2'b00};
        e.pl  = {1'b0, m_rqs, es, oq, fq, pf, 2'b00};
        e.en  = m_en;
        e.sr  = m_rqs;
        exp_q.push_back(e);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (status_byte !== e.st || poll_byte !== e.pl ||
                    ena_rdata !== e.en || srq !== e.sr) begin
                    n_bad++;
                    $display("FAIL %s: stb=%0d/%0d poll=%0d/%0d ena=%0d/%0d srq=%0b/%0b (actual/expected)",
                             e.tag, status_byte, e.st, poll_byte, e.pl,
                             ena_rdata, e.en, srq, e.sr);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; outq_busy = 0; faultq_busy = 0; psu_fault = 0; event_sum = 0;
        ena_wr = 0; ena_wdata = 0; poll_rd = 0;
        repeat (3) @(posedge clk);
        // R6 reset state, with inputs high to show they are held off
        step("R6 reset", 1, 1, 1, 1, 1, 1, 8'hFF, 0);
        step("R6 reset hold", 1, 0, 0, 0, 0, 0, 8'h00, 0);
        // R1 R2 R3: condition positions, enable still zero, no summary
        step("R3 mav set", 0, 1, 0, 0, 0, 0, 8'h00, 0);
        step("R3 mav clear", 0, 0, 0, 0, 0, 0, 8'h00, 0);
        step("R1 all conditions", 0, 1, 1, 1, 1, 0, 8'h00, 0);
        step("R1 psf only", 0, 0, 0, 1, 0, 0, 8'h00, 0);
        // R5 R10: write 255, read 56
        step("R5 write 255 reads 56", 0, 0, 0, 1, 0, 1, 8'hFF, 0);
        step("R10 enable held", 0, 0, 0, 1, 0, 0, 8'h00, 0);
        // R5: only psf enable bit written, psf must not raise summary
        step("R5 psf enable ignored", 0, 0, 0, 1, 0, 1, 8'h04, 0);
        step("R5 psf no summary", 0, 0, 0, 1, 0, 0, 8'h00, 0);
        step("R5 bit6 enable ignored", 0, 1, 1, 1, 1, 1, 8'hC7, 0);
        step("R5 no summary high bits", 0, 1, 1, 1, 1, 0, 8'h00, 0);
        // R10 R4: enable mav, summary follows one edge after
        step("R10 enable mav", 0, 1, 0, 0, 0, 1, 8'h10, 0);
        step("R4 R8 mav summary rises", 0, 1, 0, 0, 0, 0, 8'h00, 0);
        step("R8 rqs held", 0, 1, 0, 0, 0, 0, 8'h00, 0);
        // R9: poll while summary steady
        step("R9 poll clears rqs keeps mss", 0, 1, 0, 0, 0, 0, 8'h00, 1);
        step("R8 no reset without new rise", 0, 1, 0, 0, 0, 0, 8'h00, 0);
        // R4 summary falls, rqs stays clear
        step("R4 mss falls", 0, 0, 0, 0, 0, 0, 8'h00, 0);
        // R9 poll together with a new rise: set wins
        step("R9 poll at rise set wins", 0, 1, 0, 0, 0, 0, 8'h00, 1);
        step("R7 poll view rqs", 0, 1, 1, 0, 1, 0, 8'h00, 0);
        // R4 event summary and fault enables
        step("R4 enable esb flt", 0, 0, 0, 0, 0, 1, 8'h28, 1);
        step("R4 esb raises", 0, 0, 0, 0, 1, 0, 8'h00, 0);
        step("R4 flt holds", 0, 0, 1, 0, 0, 0, 8'h00, 0);
        step("R4 mav not enabled", 0, 1, 0, 1, 0, 0, 8'h00, 1);
        step("R2 spare bits", 0, 1, 1, 1, 1, 0, 8'h00, 0);
        // R6: reset mid-run clears everything
        step("R6 mid reset", 1, 1, 1, 1, 1, 0, 8'h00, 0);
        step("R6 after reset", 0, 1, 0, 0, 0, 0, 8'h00, 0);
        @(negedge clk);
        ena_wr = 0; poll_rd = 0;
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule